// File: doc/BRIEF.md
# Amplifier Gain-Error Fitness Accumulator

The block scores one candidate amplifier. It paces a fixed window of paired ADC readings, one taken from the amplifier input and one from its output, and turns them into a single number. For each pair it removes a programmable DC level from each channel. It multiplies the input deviation by a signed gain constant and takes the absolute difference from the output deviation. The differences are summed over the window. A sequential divider then returns the mean error per sample. A lower score means the amplifier is closer to the ideal inverted, amplified copy of its input.

Software writes the gain, the two channel offsets and the sample spacing through a small configuration port while the block is idle, then pulses `start`. A programmable clock divider raises `smp_tick` at the configured spacing, and the sample pair present on the inputs in that cycle is consumed at the next clock edge. After the last pair has been accumulated and divided, the block pulses `done` for one cycle. The score stays on its output until the next evaluation begins.

Top module: `amp_fit_acc`

## Requirements
- R1: While `rst_n` is low and in the first cycle after reset, `busy`, `done` and `smp_tick` are 0 and `score` is 0. Reset sets the gain register to −500 and the spacing register to 2000 cycles.
- R2: A `start` pulse while idle makes `busy` go high at the next clock edge. A `start` while `busy` is high has no effect on the running evaluation or its result.
- R3: While busy, `smp_tick` is high for one cycle in every P cycles, where P is the spacing register. A spacing of 0 behaves as 1. The first tick comes P cycles after `start` is accepted.
- R4: The error for one pair is |(out − Oout) − G·(in − Oin)|. It uses signed arithmetic that cannot overflow, for any 12-bit signed sample and any 16-bit signed gain or offset, including the extreme values.
- R5: Exactly N_SMP = 500 ticks are issued per evaluation. The result is floor(sum of the 500 errors / 500).
- R6: `done` is a single-cycle pulse. It coincides with `busy` falling and with the new `score` being valid. `score` then holds until the next start.
- R7: Configuration writes while `busy` is high are discarded. They affect neither the running evaluation nor any later one.
- R8: Configuration addresses: 0 = gain (signed), 1 = input offset (signed), 2 = output offset (signed), 3 = sample spacing in clock cycles (unsigned). A value written while idle takes effect in the next evaluation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start | input | 1 | Begin an evaluation (honoured only while idle) |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration register select |
| cfg_wdata | input | 16 | Configuration write value |
| smp_in | input | 12 | Signed ADC reading of the amplifier input |
| smp_out | input | 12 | Signed ADC reading of the amplifier output |
| smp_tick | output | 1 | High in the cycle whose sample pair is consumed |
| busy | output | 1 | Evaluation in progress |
| done | output | 1 | One-cycle pulse: score valid |
| score | output | 43 | Mean absolute error of the last window |

## Verification
The assertions assume that `start` and configuration writes come only from a synchronous source. They allow `start` to be raised at any time, including while busy, and check that it is ignored then. They also assume the ADC values are stable in each tick cycle. The stimulus changes the sample pair only just after the edge that consumed it. It drives `start` and configuration writes a short delay after a clock edge. Its deliberate mid-run `start` and gain write are the only traffic sent while busy.

// File: rtl/amp_fit_pkg.sv
package amp_fit_pkg;

  typedef enum logic [1:0] {
    CFG_GAIN    = 2'd0,
    CFG_OFF_IN  = 2'd1,
    CFG_OFF_OUT = 2'd2,
    CFG_PERIOD  = 2'd3
  } cfg_addr_e;

  localparam int unsigned DEF_SMP_W   = 12;
  localparam int unsigned DEF_CFG_W   = 16;
  localparam int unsigned DEF_N_SMP   = 500;
  localparam int          DEF_GAIN    = -500;
  localparam int unsigned DEF_PERIOD  = 2000;

endpackage

// File: rtl/amp_fit_tick.sv
module amp_fit_tick #(
  parameter int unsigned PER_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             en,
  input  logic [PER_W-1:0] period,
  output logic             tick
);

  logic [PER_W-1:0] cnt_q, cnt_d, reload;

  always_comb begin
    reload = (period == '0) ? '0 : period - PER_W'(1);
    tick   = en && (cnt_q == '0);
    cnt_d  = cnt_q;
    if (load)      cnt_d = reload;
    else if (tick) cnt_d = reload;
    else if (en)   cnt_d = cnt_q - PER_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/amp_fit_err.sv
module amp_fit_err #(
  parameter int unsigned SMP_W = 12,
  parameter int unsigned CFG_W = 16,
  localparam int unsigned DW   = CFG_W + 1,
  localparam int unsigned PW   = CFG_W + DW,
  localparam int unsigned EW   = PW + 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cap_en,
  input  logic signed [SMP_W-1:0] smp_in,
  input  logic signed [SMP_W-1:0] smp_out,
  input  logic signed [CFG_W-1:0] gain,
  input  logic signed [CFG_W-1:0] off_in,
  input  logic signed [CFG_W-1:0] off_out,
  output logic [EW-1:0]           err,
  output logic                    err_vld
);

  logic signed [DW-1:0] din_d, dout_d, din_q, dout_q;
  logic                 s1_vld_q;
  logic signed [PW-1:0] prod;
  logic signed [EW-1:0] diff;
  logic [EW-1:0]        err_d;

  // stage 1: remove DC levels
  always_comb begin
    din_d  = DW'(smp_in)  - DW'(off_in);
    dout_d = DW'(smp_out) - DW'(off_out);
  end

  // stage 2: scale, compare, magnitude
  always_comb begin
    prod  = PW'(gain) * PW'(din_q);
    diff  = EW'(dout_q) - EW'(prod);
    err_d = diff[EW-1] ? EW'(-diff) : EW'(diff);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      din_q    <= '0;
      dout_q   <= '0;
      s1_vld_q <= 1'b0;
      err      <= '0;
      err_vld  <= 1'b0;
    end else begin
      s1_vld_q <= cap_en;
      err_vld  <= s1_vld_q;
      if (cap_en) begin
        din_q  <= din_d;
        dout_q <= dout_d;
      end
      if (s1_vld_q) err <= err_d;
    end
  end

endmodule

// File: rtl/amp_fit_div.sv
module amp_fit_div #(
  parameter int unsigned AW      = 43,
  parameter int unsigned DIVISOR = 500,
  localparam int unsigned RW     = $clog2(DIVISOR + 1) + 1,
  localparam int unsigned SW     = $clog2(AW + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [AW-1:0] dividend,
  output logic [AW-1:0] quotient,
  output logic          fin
);

  logic [RW-1:0] rem_q, rem_d, trial;
  logic [AW-1:0] quo_q, quo_d;
  logic [SW-1:0] step_q, step_d;
  logic          run_q, run_d, fin_d;
  logic          fits;

  always_comb begin
    trial  = {rem_q[RW-2:0], quo_q[AW-1]};
    fits   = (trial >= RW'(DIVISOR));
    rem_d  = rem_q;
    quo_d  = quo_q;
    step_d = step_q;
    run_d  = run_q;
    fin_d  = 1'b0;
    if (go) begin
      rem_d  = '0;
      quo_d  = dividend;
      step_d = SW'(AW);
      run_d  = 1'b1;
    end else if (run_q) begin
      rem_d  = fits ? trial - RW'(DIVISOR) : trial;
      quo_d  = {quo_q[AW-2:0], fits};
      step_d = step_q - SW'(1);
      if (step_q == SW'(1)) begin
        run_d = 1'b0;
        fin_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      quo_q  <= '0;
      step_q <= '0;
      run_q  <= 1'b0;
      fin    <= 1'b0;
    end else begin
      rem_q  <= rem_d;
      quo_q  <= quo_d;
      step_q <= step_d;
      run_q  <= run_d;
      fin    <= fin_d;
    end
  end

  assign quotient = quo_q;

endmodule

// File: rtl/amp_fit_acc.sv
module amp_fit_acc
  import amp_fit_pkg::*;
#(
  parameter int unsigned SMP_W  = DEF_SMP_W,
  parameter int unsigned CFG_W  = DEF_CFG_W,
  parameter int unsigned N_SMP  = DEF_N_SMP,
  localparam int unsigned EW    = 2 * CFG_W + 2,
  localparam int unsigned CNT_W = $clog2(N_SMP + 1),
  localparam int unsigned AW    = EW + CNT_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic                    cfg_we,
  input  logic [1:0]              cfg_addr,
  input  logic [CFG_W-1:0]        cfg_wdata,
  input  logic signed [SMP_W-1:0] smp_in,
  input  logic signed [SMP_W-1:0] smp_out,
  output logic                    smp_tick,
  output logic                    busy,
  output logic                    done,
  output logic [AW-1:0]           score
);

  logic signed [CFG_W-1:0] gain_q, off_in_q, off_out_q;
  logic [CFG_W-1:0]        period_q;
  logic                    cfg_en;

  logic              go;
  logic              tick_en;
  logic [CNT_W-1:0]  issued_q, issued_d;
  logic [CNT_W-1:0]  taken_q, taken_d;
  logic [AW-1:0]     acc_q, acc_d, acc_sum;
  logic              busy_d, done_d;
  logic [AW-1:0]     score_d;
  logic              last_err;

  logic [EW-1:0]     err;
  logic              err_vld;
  logic [AW-1:0]     quotient;
  logic              div_fin;

  // configuration: accepted only while idle
  assign cfg_en = cfg_we && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gain_q    <= CFG_W'(DEF_GAIN);
      off_in_q  <= '0;
      off_out_q <= '0;
      period_q  <= CFG_W'(DEF_PERIOD);
    end else if (cfg_en) begin
      unique case (cfg_addr_e'(cfg_addr))
        CFG_GAIN:    gain_q    <= cfg_wdata;
        CFG_OFF_IN:  off_in_q  <= cfg_wdata;
        CFG_OFF_OUT: off_out_q <= cfg_wdata;
        CFG_PERIOD:  period_q  <= cfg_wdata;
        default:     ;
      endcase
    end
  end

  assign go      = start && !busy;
  assign tick_en = busy && (issued_q != CNT_W'(N_SMP));

  amp_fit_tick #(.PER_W(CFG_W)) u_tick (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (go),
    .en     (tick_en),
    .period (period_q),
    .tick   (smp_tick)
  );

  amp_fit_err #(.SMP_W(SMP_W), .CFG_W(CFG_W)) u_err (
    .clk     (clk),
    .rst_n   (rst_n),
    .cap_en  (smp_tick),
    .smp_in  (smp_in),
    .smp_out (smp_out),
    .gain    (gain_q),
    .off_in  (off_in_q),
    .off_out (off_out_q),
    .err     (err),
    .err_vld (err_vld)
  );

  assign acc_sum  = acc_q + AW'(err);
  assign last_err = err_vld && (taken_q == CNT_W'(N_SMP - 1));

  amp_fit_div #(.AW(AW), .DIVISOR(N_SMP)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .go       (last_err),
    .dividend (acc_sum),
    .quotient (quotient),
    .fin      (div_fin)
  );

  always_comb begin
    issued_d = issued_q;
    taken_d  = taken_q;
    acc_d    = acc_q;
    busy_d   = busy;
    done_d   = 1'b0;
    score_d  = score;
    if (go) begin
      issued_d = '0;
      taken_d  = '0;
      acc_d    = '0;
      busy_d   = 1'b1;
    end else begin
      if (smp_tick) issued_d = issued_q + CNT_W'(1);
      if (err_vld) begin
        taken_d = taken_q + CNT_W'(1);
        acc_d   = acc_sum;
      end
      if (div_fin) begin
        busy_d  = 1'b0;
        done_d  = 1'b1;
        score_d = quotient;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      issued_q <= '0;
      taken_q  <= '0;
      acc_q    <= '0;
      busy     <= 1'b0;
      done     <= 1'b0;
      score    <= '0;
    end else begin
      issued_q <= issued_d;
      taken_q  <= taken_d;
      acc_q    <= acc_d;
      busy     <= busy_d;
      done     <= done_d;
      score    <= score_d;
    end
  end

endmodule

// File: rtl/amp_fit_acc_chk.sv
module amp_fit_acc_chk #(
  parameter int unsigned CFG_W = 16,
  parameter int unsigned AW    = 43
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             busy,
  input logic             done,
  input logic             smp_tick,
  input logic [AW-1:0]    score,
  input logic [CFG_W-1:0] gain_q,
  input logic [CFG_W-1:0] period_q
);

  p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  p_busy_needs_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

  p_tick_in_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    smp_tick |-> busy);

  p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  p_score_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(score));

  p_cfg_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(gain_q) && $stable(period_q)));

endmodule

bind amp_fit_acc amp_fit_acc_chk #(.CFG_W(CFG_W), .AW(AW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .busy     (busy),
  .done     (done),
  .smp_tick (smp_tick),
  .score    (score),
  .gain_q   (gain_q),
  .period_q (period_q)
);

// File: tb/amp_fit_acc_bench.sv
module amp_fit_acc_bench;

  localparam int SMP_W = 12;
  localparam int CFG_W = 16;
  localparam int N     = 500;
  localparam int AW    = 2 * CFG_W + 2 + $clog2(N + 1);

  logic                    clk = 1'b0;
  logic                    rst_n;
  logic                    start;
  logic                    cfg_we;
  logic [1:0]              cfg_addr;
  logic [CFG_W-1:0]        cfg_wdata;
  logic signed [SMP_W-1:0] smp_in, smp_out;
  logic                    smp_tick, busy, done;
  logic [AW-1:0]           score;

  always #2.5 clk = ~clk;

  amp_fit_acc u_amp_fit_acc (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .smp_in(smp_in),
    .smp_out(smp_out), .smp_tick(smp_tick), .busy(busy), .done(done),
    .score(score)
  );

  int    n_checks = 0;
  int    n_fail   = 0;
  longint exp_q[$];
  string  tag_q[$];
  int    done_cnt = 0;

  // tick spacing monitor
  longint cyc = 0, prev_tick = 0;
  bit     have_prev = 0;
  int     tick_n = 0, bad_sp = 0, exp_per = 1;

  // model configuration
  longint m_gain = -500, m_oi = 0, m_oo = 0;

  task automatic check(bit ok, string req, longint act, longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cfg_write(logic [1:0] a, longint v);
    @(posedge clk); #1;
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = CFG_W'(v);
    @(posedge clk); #1;
    cfg_we = 1'b0;
    if (!busy) begin
      case (a)
        2'd0: m_gain = longint'($signed(CFG_W'(v)));
        2'd1: m_oi   = longint'($signed(CFG_W'(v)));
        2'd2: m_oo   = longint'($signed(CFG_W'(v)));
        default: ;
      endcase
    end
  endtask

  // mode 0 random, 1 extremes, 2 exact (zero error)
  task automatic run_eval(int per, int mode, bit inject, string tag);
    longint sum = 0;
    longint vi, vo, e;
    int     want_done;
    exp_per = (per == 0) ? 1 : per;
    have_prev = 0; tick_n = 0; bad_sp = 0;
    want_done = done_cnt + 1;
    @(posedge clk); #1;
    start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    check(busy == 1'b1, "R2 busy after start", busy, 1);
    for (int i = 0; i < N; i++) begin
      if (mode == 0) begin
        vi = $urandom_range(4095) - 2048;
        vo = $urandom_range(4095) - 2048;
      end else if (mode == 1) begin
        vi = (i % 2 == 0) ? -2048 : 2047;
        vo = (i % 2 == 0) ?  2047 : -2048;
      end else begin
        vi = longint'($urandom_range(2000)) - 1000;
        vo = m_oo + m_gain * (vi - m_oi);
      end
      smp_in  = SMP_W'(vi);
      smp_out = SMP_W'(vo);
      if (inject && i == 100) begin
        start = 1'b1; cfg_we = 1'b1; cfg_addr = 2'd0; cfg_wdata = 16'd9;
        @(posedge clk); #1;
        start = 1'b0; cfg_we = 1'b0;
      end
      do @(negedge clk); while (!smp_tick);
      e = (vo - m_oo) - m_gain * (vi - m_oi);
      sum += (e < 0) ? -e : e;
      @(posedge clk); #1;
    end
    exp_q.push_back(sum / N);
    tag_q.push_back(tag);
    while (done_cnt < want_done) @(negedge clk);
    check(tick_n == N, "R5 tick count", tick_n, N);
    check(bad_sp == 0, "R3 tick spacing", bad_sp, 0);
  endtask

  always @(negedge clk) begin
    cyc++;
    if (smp_tick) begin
      if (have_prev && (cyc - prev_tick) != exp_per) bad_sp++;
      prev_tick = cyc;
      have_prev = 1;
      tick_n++;
    end
  end

  // scoreboard monitor
  initial begin
    longint exp, held;
    string  t;
    forever begin
      @(negedge clk);
      if (done) begin
        if (exp_q.size() == 0) begin
          check(0, "R6 unexpected done", 1, 0);
        end else begin
          exp = exp_q.pop_front();
          t   = tag_q.pop_front();
          check(longint'(score) == exp, t, longint'(score), exp);
          check(busy == 1'b0, "R6 busy low with done", busy, 0);
        end
        held = longint'(score);
        @(negedge clk);
        check(done == 1'b0, "R6 done one cycle", done, 0);
        repeat (3) @(negedge clk);
        check(longint'(score) == held, "R6 score held", longint'(score), held);
        done_cnt++;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    check(0, "watchdog", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    smp_in = '0; smp_out = '0;
    repeat (3) @(posedge clk);
    #1;
    check(busy == 0 && done == 0 && smp_tick == 0 && score == '0,
          "R1 reset outputs", longint'(score), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy == 0 && done == 0 && smp_tick == 0 && score == '0,
          "R1 after release", longint'(score), 0);

    // default gain -500 from reset, offsets programmed (R1, R4, R5, R8)
    cfg_write(2'd1, 100);
    cfg_write(2'd2, -50);
    cfg_write(2'd3, 3);
    run_eval(3, 0, 0, "R5 R8 default gain random");

    // extreme values with most negative gain, spacing 0 (R3, R4)
    cfg_write(2'd0, -32768);
    cfg_write(2'd1, 2047);
    cfg_write(2'd2, -2048);
    cfg_write(2'd3, 0);
    run_eval(0, 1, 0, "R4 extremes no overflow");

    // positive gain; mid-run start and gain write ignored (R2, R7)
    cfg_write(2'd0, 3);
    cfg_write(2'd1, 0);
    cfg_write(2'd2, 0);
    cfg_write(2'd3, 2);
    run_eval(2, 0, 1, "R2 R7 mid-run start and write");

    // next evaluation still uses gain 3 (R7)
    run_eval(2, 0, 0, "R7 discarded write has no later effect");

    // exact amplifier: zero error (R5)
    cfg_write(2'd0, -1);
    cfg_write(2'd1, 5);
    cfg_write(2'd2, -7);
    cfg_write(2'd3, 4);
    run_eval(4, 2, 0, "R5 zero error");

    repeat (10) @(negedge clk);
    check(exp_q.size() == 0, "R6 all results seen", exp_q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule